// File: doc/BRIEF.md
# Power Converter Operating-Mode Sequencer

This block is the digital supervisor of a switching power controller. It receives already-synchronised comparator flags about the supply rail, the feedback and opto inputs, and the fault detectors. From these it decides whether the power switch may be driven, whether the high-voltage startup charger is on, and which charging current that charger should use. It also reports its current operating mode as a small binary code.

The sequencer moves through five modes: start-up, ramp-up, active, stop and low consumption. It owns the timers that qualify slow faults (brownout, overpower), the fixed ramp-up window after first power-up, and the dwell timer that holds the stop and low-consumption modes before an automatic restart. Every duration is a parameter counted in clock cycles. Fast faults, overcurrent and input overvoltage, gate the switch enable at once, without waiting for a clock edge.

Top module: `pmode_seq`

## Requirements
- R1: The mode output uses a fixed binary code: 0 start-up, 1 ramp-up, 2 active, 3 stop, 4 low consumption. After reset the code is 0.
- R2: Start-up is left only on a clock edge where the supply is above the turn-on level, the feedback and opto inputs are both in range, and input overvoltage is absent.
- R3: The first start-up after reset leads to ramp-up. Every later start-up leads straight to active.
- R4: Ramp-up drives the switch like active, but it ignores the brownout and overpower flags. It moves to active once TSS_CYC clock edges have passed since reset was released.
- R5: An overcurrent flag clears the switch enable in the same cycle. In ramp-up or active it moves the block to stop. Stop then lasts OCP_CYC cycles, and the block resumes once overvoltage is absent.
- R6: In active, a brownout flag sampled high on BO_CYC consecutive edges moves the block to stop. After REC_CYC cycles there it returns to start-up.
- R7: In active, an overpower flag sampled high on OPP_CYC consecutive edges moves the block to low consumption. It stays there at least REC_CYC cycles before it returns to start-up.
- R8: An input overvoltage flag clears the switch enable in the same cycle, in every mode. It moves ramp-up or active to stop, where the block waits until the flag clears. It also blocks the exit from start-up.
- R9: Stop moves to low consumption when the opto input is below its disable level or the supply is below the sustain level. Ramp-up and active move to low consumption when the supply is below the sustain level.
- R10: The charger is enabled only in start-up and low consumption. While it is on, the high-current select is 1 when the supply is above the sustain level and 0 when it is below.
- R11: A supply-below-reset flag forces start-up on the next edge and restores the first power-up history, so the next start-up goes to ramp-up again.
- R12: Low consumption returns to start-up only after its dwell has expired and while the opto input is not below its disable level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_below_rst | input | 1 | Supply is below the logic reset level (synchronous clear) |
| vcc_above_on | input | 1 | Supply is above the turn-on level |
| vcc_above_sus | input | 1 | Supply is above the startup sustain level |
| fb_in_range | input | 1 | Feedback pin is in its operating range |
| opto_in_range | input | 1 | Opto pin is in its operating range |
| opto_below_dis | input | 1 | Opto pin is below its disable level |
| ocp_flag | input | 1 | Second-level overcurrent detected |
| bo_flag | input | 1 | Brownout condition present |
| opp_flag | input | 1 | Overpower condition present |
| ovp_flag | input | 1 | Input overvoltage present |
| sw_en | output | 1 | Switching enable for the gate stage |
| chg_en | output | 1 | High-voltage startup charger enable |
| chg_hi_sel | output | 1 | Charger current select, 1 selects the high current |
| mode_code | output | 3 | Current operating mode code |

## Verification
The bench steps the block through a first power-up in which the supply comes up while the feedback input is still out of range and overvoltage is present. This shows that each start-up exit condition is needed on its own. A brownout applied during ramp-up, and the same brownout applied during active, show the ramp window masking the slow faults. Overcurrent, brownout, overpower and overvoltage are each applied in active. The cycle count spent in stop or low consumption, and the mode that follows, tell the short overcurrent dwell from the long recovery dwell, and tell a restart through start-up from a direct resume. Supply drops, opto disable and a reset-level supply flag then exercise the exits to low consumption and the return of the first power-up path.

// File: rtl/pmode_pkg.sv
package pmode_pkg;
   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      MD_START  = 3'd0,
      MD_RAMP   = 3'd1,
      MD_ACTIVE = 3'd2,
      MD_STOP   = 3'd3,
      MD_LOWC   = 3'd4
   } mode_e;

   typedef enum logic [1:0] {
      HC_NONE  = 2'd0,
      HC_OCP   = 2'd1,
      HC_BROWN = 2'd2,
      HC_OVP   = 2'd3
   } hold_e;

   localparam int N_PERSIST = 2;
   localparam int PERS_BO   = 0;
   localparam int PERS_OPP  = 1;
endpackage

// File: rtl/pmode_persist.sv
module pmode_persist #(
   parameter int LIMIT = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   input  logic flag,
   output logic trip
);
   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt;

   // trips on the LIMIT-th consecutive enabled high sample
   assign trip = en && flag && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr || !(en && flag) || trip) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pmode_ramp_timer.sv
module pmode_ramp_timer #(
   parameter int LIMIT = 850
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic done
);
   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt;

   assign done = (cnt == CW'(LIMIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (!done) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pmode_dwell.sv
module pmode_dwell #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] val,
   input  logic         run,
   output logic         zero
);
   logic [W-1:0] cnt;

   assign zero = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= val;
      end else if (run && !zero) begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/pmode_seq.sv
module pmode_seq
   import pmode_pkg::*;
#(
   parameter int TSS_CYC = 850,
   parameter int OCP_CYC = 10,
   parameter int BO_CYC  = 100,
   parameter int OPP_CYC = 100,
   parameter int REC_CYC = 2500
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vcc_below_rst,
   input  logic              vcc_above_on,
   input  logic              vcc_above_sus,
   input  logic              fb_in_range,
   input  logic              opto_in_range,
   input  logic              opto_below_dis,
   input  logic              ocp_flag,
   input  logic              bo_flag,
   input  logic              opp_flag,
   input  logic              ovp_flag,
   output logic              sw_en,
   output logic              chg_en,
   output logic              chg_hi_sel,
   output logic [MODE_W-1:0] mode_code
);
   localparam int DW_MAX = (OCP_CYC > REC_CYC) ? OCP_CYC : REC_CYC;
   localparam int DW     = $clog2(DW_MAX + 1);
   localparam logic [DW-1:0] OCP_LD = DW'(OCP_CYC - 1);
   localparam logic [DW-1:0] REC_LD = DW'(REC_CYC - 1);

   if (TSS_CYC < 1) begin : g_bad_tss
      $error("TSS_CYC must be at least 1");
   end
   if (OCP_CYC < 1 || REC_CYC < 1) begin : g_bad_dwell
      $error("dwell lengths must be at least 1");
   end
   if (BO_CYC < 1 || OPP_CYC < 1) begin : g_bad_pers
      $error("persistence limits must be at least 1");
   end

   mode_e   mode, nxt;
   hold_e   cause, cause_n;
   logic    first_pu, first_n;
   logic    ramp_done;
   logic    dw_load, dw_zero, dw_run;
   logic [DW-1:0] dw_val;
   logic [N_PERSIST-1:0] pers_flag, pers_trip;
   logic    in_drive;
   mode_e   resume;
   logic    start_ok;

   assign pers_flag[PERS_BO]  = bo_flag;
   assign pers_flag[PERS_OPP] = opp_flag;

   for (genvar gi = 0; gi < N_PERSIST; gi++) begin : g_pers
      localparam int LIM = (gi == PERS_BO) ? BO_CYC : OPP_CYC;
      pmode_persist #(.LIMIT(LIM)) u_pers (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (vcc_below_rst),
         .en    (mode == MD_ACTIVE),
         .flag  (pers_flag[gi]),
         .trip  (pers_trip[gi])
      );
   end

   pmode_ramp_timer #(.LIMIT(TSS_CYC)) u_ramp (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (vcc_below_rst),
      .done  (ramp_done)
   );

   assign dw_run = (mode == MD_STOP) || (mode == MD_LOWC);

   pmode_dwell #(.W(DW)) u_dwell (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (vcc_below_rst),
      .load  (dw_load),
      .val   (dw_val),
      .run   (dw_run),
      .zero  (dw_zero)
   );

   assign resume   = ramp_done ? MD_ACTIVE : MD_RAMP;
   assign start_ok = vcc_above_on && fb_in_range && opto_in_range && !ovp_flag;

   always_comb begin
      nxt     = mode;
      cause_n = cause;
      first_n = first_pu;
      dw_load = 1'b0;
      dw_val  = '0;
      unique case (mode)
         MD_START: begin
            if (start_ok) begin
               nxt     = first_pu ? MD_RAMP : MD_ACTIVE;
               first_n = 1'b0;
            end
         end
         MD_RAMP, MD_ACTIVE: begin
            if (ovp_flag) begin
               nxt     = MD_STOP;
               cause_n = HC_OVP;
               dw_load = 1'b1;
            end else if (!vcc_above_sus) begin
               nxt     = MD_LOWC;
               cause_n = HC_NONE;
               dw_load = 1'b1;
            end else if (ocp_flag) begin
               nxt     = MD_STOP;
               cause_n = HC_OCP;
               dw_load = 1'b1;
               dw_val  = OCP_LD;
            end else if (pers_trip[PERS_BO]) begin
               nxt     = MD_STOP;
               cause_n = HC_BROWN;
               dw_load = 1'b1;
               dw_val  = REC_LD;
            end else if (pers_trip[PERS_OPP]) begin
               nxt     = MD_LOWC;
               cause_n = HC_NONE;
               dw_load = 1'b1;
               dw_val  = REC_LD;
            end else if (mode == MD_RAMP && ramp_done) begin
               nxt = MD_ACTIVE;
            end
         end
         MD_STOP: begin
            if (!vcc_above_sus || opto_below_dis) begin
               nxt     = MD_LOWC;
               cause_n = HC_NONE;
               dw_load = 1'b1;
            end else begin
               unique case (cause)
                  HC_OVP:   if (!ovp_flag) nxt = resume;
                  HC_BROWN: if (dw_zero) nxt = MD_START;
                  default:  if (dw_zero && !ovp_flag) nxt = resume;
               endcase
            end
         end
         MD_LOWC: begin
            if (dw_zero && !opto_below_dis) nxt = MD_START;
         end
         default: nxt = MD_START;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= MD_START;
         cause    <= HC_NONE;
         first_pu <= 1'b1;
      end else if (vcc_below_rst) begin
         mode     <= MD_START;
         cause    <= HC_NONE;
         first_pu <= 1'b1;
      end else begin
         mode     <= nxt;
         cause    <= cause_n;
         first_pu <= first_n;
      end
   end

   assign in_drive   = (mode == MD_RAMP) || (mode == MD_ACTIVE);
   assign sw_en      = in_drive && !ovp_flag && !ocp_flag;
   assign chg_en     = (mode == MD_START) || (mode == MD_LOWC);
   assign chg_hi_sel = chg_en && vcc_above_sus;
   assign mode_code  = mode;
endmodule

// File: rtl/pmode_seq_chk.sv
module pmode_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       vcc_below_rst,
   input logic       vcc_above_on,
   input logic       vcc_above_sus,
   input logic       fb_in_range,
   input logic       opto_in_range,
   input logic       opto_below_dis,
   input logic       ocp_flag,
   input logic       ovp_flag,
   input logic       sw_en,
   input logic       chg_en,
   input logic       chg_hi_sel,
   input logic [2:0] mode_code
);
   a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      mode_code <= 3'd4);

   a_r2_start_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 3'd0 && !(vcc_above_on && fb_in_range && opto_in_range))
      |=> mode_code == 3'd0);

   a_r5_ocp_gate: assert property (@(posedge clk) disable iff (!rst_n)
      ocp_flag |-> !sw_en);

   a_r8_ovp_gate: assert property (@(posedge clk) disable iff (!rst_n)
      ovp_flag |-> !sw_en);

   a_r8_ovp_start_block: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 3'd0 && ovp_flag) |=> mode_code == 3'd0);

   a_r10_chg_off: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 3'd1 || mode_code == 3'd2 || mode_code == 3'd3) |-> !chg_en);

   a_r10_hi_sel: assert property (@(posedge clk) disable iff (!rst_n)
      chg_hi_sel |-> (chg_en && vcc_above_sus));

   a_r11_rst_flag: assert property (@(posedge clk) disable iff (!rst_n)
      vcc_below_rst |=> mode_code == 3'd0);

   a_r9_stop_to_lowc: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 3'd3 && opto_below_dis && !vcc_below_rst) |=> mode_code == 3'd4);
endmodule

bind pmode_seq pmode_seq_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .vcc_below_rst  (vcc_below_rst),
   .vcc_above_on   (vcc_above_on),
   .vcc_above_sus  (vcc_above_sus),
   .fb_in_range    (fb_in_range),
   .opto_in_range  (opto_in_range),
   .opto_below_dis (opto_below_dis),
   .ocp_flag       (ocp_flag),
   .ovp_flag       (ovp_flag),
   .sw_en          (sw_en),
   .chg_en         (chg_en),
   .chg_hi_sel     (chg_hi_sel),
   .mode_code      (mode_code)
);

// File: tb/pmode_seq_tb.sv
`timescale 1ns/1ps
module pmode_seq_tb;
   localparam int TSS = 60;
   localparam int TOC = 5;
   localparam int TBO = 8;
   localparam int TOP = 8;
   localparam int TRC = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vrst = 1'b0, von = 1'b0, vsus = 1'b0, fbok = 1'b0, opok = 1'b0;
   logic opdis = 1'b0, ocp = 1'b0, bo = 1'b0, opp = 1'b0, ovp = 1'b0;
   logic sw_en, chg_en, chg_hi_sel;
   logic [2:0] mode_code;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   string cur_tag = "R1";

   always #5 clk = ~clk;

   pmode_seq #(.TSS_CYC(TSS), .OCP_CYC(TOC), .BO_CYC(TBO), .OPP_CYC(TOP), .REC_CYC(TRC)) u_dut (
      .clk(clk), .rst_n(rst_n), .vcc_below_rst(vrst), .vcc_above_on(von),
      .vcc_above_sus(vsus), .fb_in_range(fbok), .opto_in_range(opok),
      .opto_below_dis(opdis), .ocp_flag(ocp), .bo_flag(bo), .opp_flag(opp),
      .ovp_flag(ovp), .sw_en(sw_en), .chg_en(chg_en), .chg_hi_sel(chg_hi_sel),
      .mode_code(mode_code)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
      end
   endtask

   // reference model: modes 0 start, 1 ramp, 2 active, 3 stop, 4 low consumption
   int m_mode = 0, m_first = 1, m_ramp_age = 0, m_dwell = 0;
   int m_bo_run = 0, m_opp_run = 0;
   int m_hold = 0; // 0 none, 1 overcurrent, 2 brownout, 3 overvoltage

   task automatic model_clear();
      m_mode = 0; m_first = 1; m_ramp_age = 0; m_dwell = 0;
      m_bo_run = 0; m_opp_run = 0; m_hold = 0;
   endtask

   task automatic model_step();
      int  nm;
      bit  ramp_over, bo_hit, opp_hit, loaded;
      int  back;
      if (vrst) begin
         model_clear();
         return;
      end
      ramp_over = (m_ramp_age >= TSS);
      if (!ramp_over) m_ramp_age++;
      back = ramp_over ? 2 : 1;
      bo_hit = 1'b0; opp_hit = 1'b0;
      if (m_mode == 2 && bo) begin
         if (m_bo_run == TBO - 1) begin bo_hit = 1'b1; m_bo_run = 0; end
         else m_bo_run++;
      end else m_bo_run = 0;
      if (m_mode == 2 && opp) begin
         if (m_opp_run == TOP - 1) begin opp_hit = 1'b1; m_opp_run = 0; end
         else m_opp_run++;
      end else m_opp_run = 0;
      nm = m_mode;
      loaded = 1'b0;
      case (m_mode)
         0: if (von && fbok && opok && !ovp) begin
               nm = m_first ? 1 : 2;
               m_first = 0;
            end
         1, 2: begin
            if (ovp) begin nm = 3; m_hold = 3; m_dwell = 0; loaded = 1'b1; end
            else if (!vsus) begin nm = 4; m_hold = 0; m_dwell = 0; loaded = 1'b1; end
            else if (ocp) begin nm = 3; m_hold = 1; m_dwell = TOC - 1; loaded = 1'b1; end
            else if (bo_hit) begin nm = 3; m_hold = 2; m_dwell = TRC - 1; loaded = 1'b1; end
            else if (opp_hit) begin nm = 4; m_hold = 0; m_dwell = TRC - 1; loaded = 1'b1; end
            else if (m_mode == 1 && ramp_over) nm = 2;
         end
         3: begin
            if (!vsus || opdis) begin nm = 4; m_hold = 0; m_dwell = 0; loaded = 1'b1; end
            else if (m_hold == 3) begin if (!ovp) nm = back; end
            else if (m_hold == 2) begin if (m_dwell == 0) nm = 0; end
            else if (m_dwell == 0 && !ovp) nm = back;
         end
         default: if (m_dwell == 0 && !opdis) nm = 0;
      endcase
      if (!loaded && (m_mode == 3 || m_mode == 4) && m_dwell > 0) m_dwell--;
      m_mode = nm;
   endtask

   always @(posedge clk) begin
      if (!rst_n) model_clear();
      else model_step();
      #2;
      if (rst_n && !finished) begin
         chk({cur_tag, " mode"}, int'(mode_code), m_mode);
         chk({cur_tag, " sw_en"}, int'(sw_en), int'((m_mode == 1 || m_mode == 2) && !ovp && !ocp));
         chk({cur_tag, " chg_en"}, int'(chg_en), int'(m_mode == 0 || m_mode == 4));
         chk({cur_tag, " chg_hi_sel"}, int'(chg_hi_sel), int'((m_mode == 0 || m_mode == 4) && vsus));
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_mode(input int m, input int lim, input string tag);
      int n = 0;
      while (int'(mode_code) != m && n < lim) begin
         tick(1);
         n++;
      end
      chk(tag, int'(mode_code), m);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      #1;
      chk("R1 reset code", int'(mode_code), 0);
      chk("R10 reset charger on", int'(chg_en), 1);
      chk("R10 low current below sustain", int'(chg_hi_sel), 0);
      chk("R1 reset no switching", int'(sw_en), 0);

      cur_tag = "R10";
      tick(1); vsus = 1'b1; #1;
      chk("R10 high current above sustain", int'(chg_hi_sel), 1);

      cur_tag = "R2";
      tick(1); von = 1'b1; opok = 1'b1;
      tick(5);
      chk("R2 feedback out of range holds start", int'(mode_code), 0);
      cur_tag = "R8";
      ovp = 1'b1; fbok = 1'b1;
      tick(3);
      chk("R8 overvoltage blocks start exit", int'(mode_code), 0);
      cur_tag = "R3";
      ovp = 1'b0;
      wait_mode(1, 4, "R3 first start goes to ramp");
      #1;
      chk("R10 charger off in ramp", int'(chg_en), 0);
      chk("R4 ramp drives switch", int'(sw_en), 1);

      cur_tag = "R4";
      bo = 1'b1; opp = 1'b1;
      tick(15);
      chk("R4 ramp ignores brownout and overpower", int'(mode_code), 1);
      bo = 1'b0; opp = 1'b0;
      wait_mode(2, TSS + 5, "R4 ramp ends in active");

      cur_tag = "R5";
      tick(2); ocp = 1'b1; #1;
      chk("R5 overcurrent gates switch at once", int'(sw_en), 0);
      tick(1); ocp = 1'b0;
      chk("R5 overcurrent enters stop", int'(mode_code), 3);
      wait_mode(2, TOC + 3, "R5 resume after overcurrent dwell");

      cur_tag = "R6";
      bo = 1'b1;
      tick(TBO - 4);
      chk("R6 short brownout tolerated", int'(mode_code), 2);
      wait_mode(3, 8, "R6 brownout enters stop");
      bo = 1'b0;
      wait_mode(0, TRC + 4, "R6 restart through start-up");
      tick(1);
      chk("R3 later start goes to active", int'(mode_code), 2);

      cur_tag = "R7";
      opp = 1'b1;
      wait_mode(4, TOP + 3, "R7 overpower enters low consumption");
      opp = 1'b0;
      #1;
      chk("R10 charger on in low consumption", int'(chg_en), 1);
      wait_mode(0, TRC + 4, "R7 restart after recovery");
      tick(1);
      chk("R7 active after restart", int'(mode_code), 2);

      cur_tag = "R8";
      ovp = 1'b1; #1;
      chk("R8 overvoltage gates switch at once", int'(sw_en), 0);
      tick(1);
      chk("R8 overvoltage enters stop", int'(mode_code), 3);
      tick(3);
      chk("R8 stop held while overvoltage", int'(mode_code), 3);
      cur_tag = "R9";
      opdis = 1'b1;
      tick(1);
      chk("R9 opto disable from stop", int'(mode_code), 4);
      cur_tag = "R12";
      ovp = 1'b0;
      tick(3);
      chk("R12 low consumption waits for opto", int'(mode_code), 4);
      opdis = 1'b0;
      wait_mode(0, 3, "R12 leave low consumption");
      wait_mode(2, 3, "R12 back to active");

      cur_tag = "R9";
      vsus = 1'b0; von = 1'b0;
      tick(1);
      chk("R9 supply drop from active", int'(mode_code), 4);
      #1;
      chk("R10 low current in low consumption", int'(chg_hi_sel), 0);
      vsus = 1'b1;
      wait_mode(0, 3, "R12 exit with no dwell");
      tick(2);
      chk("R2 start held below turn-on", int'(mode_code), 0);
      von = 1'b1;
      wait_mode(2, 3, "R3 active after low consumption");

      cur_tag = "R11";
      vrst = 1'b1;
      tick(1);
      chk("R11 reset flag forces start", int'(mode_code), 0);
      vrst = 1'b0;
      wait_mode(1, 4, "R11 first power-up history restored");
      tick(5);
      summary();
   end
endmodule